// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven master for the two-wire PHY management bus. Software stores a 16-bit value in a data register and then writes a single command word naming the PHY, the register inside that PHY, and the direction. The controller divides the system clock down to the management clock, sends a preamble and the clause-22 frame, and either shifts the stored value out or captures 16 bits from the PHY.

A self-clearing busy flag in the command word both launches a transaction and reports its progress. Software polls the flag until it reads 0. After a read, the captured value is then in the data register. The management data pin comes out as three signals: a data output, an output enable, and a data input. An external pad or a pull-up resolves the shared line.

Top module: `mdio_master`

## Requirements
- R1: Writing the command word with bit 0 = 1 while idle launches one frame. Bit 0 reads back 1 for the whole frame and returns to 0 once the frame has completed. Exactly one frame is sent per launch.
- R2: Command bit 1 selects the direction: 1 is a write and is sent with opcode bits 0,1; 0 is a read and is sent with opcode bits 1,0.
- R3: The PHY register number is taken from command bits 8:4 and sent MSB first, directly after the PHY address.
- R4: The PHY address is taken from command bits 16:12 and sent MSB first, directly after the opcode.
- R5: On a write, the bits after the opcode and addresses are the turnaround pattern 1,0 followed by the data register value (register select 1, bits 15:0), MSB first.
- R6: On a read, the output enable is low for the two turnaround bits and all 16 data bits. The line is sampled on the MDC rising edge. Once bit 0 reads 0, the data register holds the 16 sampled bits, first bit in bit 15.
- R7: Every frame begins with 32 ones, then the start pattern 0,1. MDIO changes only while MDC is low.
- R8: MDC has a period of 2*HALF_DIV system clocks (20 by default, which is 2.5 MHz from 50 MHz). MDC is held low while idle.
- R9: A command write while bit 0 reads 1 is ignored. The frame in flight and the fields read back are unchanged.
- R10: After reset the command word reads 0, MDC is low and the output enable is low.
- R11: A command write with bit 0 = 0 stores the fields for readback but sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 command word, 1 data register |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Read data of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift register shows up on the serial line within one bit time of the error, so the whole 64-bit frame is captured at each MDC rise and compared bit for bit. A busy flag that sticks or clears early shows up in polling: it gives a missing or truncated frame and, on reads, a data register that does not match what the responder drove. A divider fault changes the measured MDC period on the first two rising edges. Command fields that change under a busy transaction corrupt the address bits of the frame in flight and the readback that follows it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_BITS = 32;
  localparam int FRAME_W  = PRE_BITS + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int TA_IDX   = FRAME_W - DATA_W - 2;
  localparam int DATA_IDX = FRAME_W - DATA_W;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int BUSY_BIT = 0;
  localparam int WR_BIT   = 1;
  localparam int REG_LSB  = 4;
  localparam int PHY_LSB  = 12;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    op  = wr ? 2'b01 : 2'b10;
    ta  = wr ? 2'b10 : 2'b11;
    pay = wr ? data : '1;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = en_i && (cnt_q == CNT_W'(HALF_DIV - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] regad_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] cap_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               active_q;
  logic               rd_q;
  logic [DATA_W-1:0]  cap_q;
  logic               last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
  assign done_o   = active_q && fall_i && last_bit;
  assign mdio_o   = active_q ? frame_q[FRAME_W-1] : 1'b1;
  // release the line from turnaround to the end of a read
  assign oe_o     = active_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
  assign cap_o    = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cap_q    <= '0;
    end else if (start_i) begin
      frame_q  <= build_frame(wr_i, phy_i, regad_i, wdata_i);
      idx_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= !wr_i;
    end else if (active_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          active_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= frame_q << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10,
  parameter int REG_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic              busy_q;
  logic              wr_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] regad_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_acc;
  logic              launch;
  logic              rise, fall, done;
  logic [DATA_W-1:0] cap;
  logic [2*ADDR_W:0] cmd_fields;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign cmd_acc    = reg_we_i && !reg_sel_i && !busy_q;
  assign launch     = cmd_acc && reg_wdata_i[BUSY_BIT];
  assign cmd_fields = {wr_q, phy_q, regad_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      phy_q   <= '0;
      regad_q <= '0;
    end else if (cmd_acc) begin
      busy_q  <= reg_wdata_i[BUSY_BIT];
      wr_q    <= reg_wdata_i[WR_BIT];
      phy_q   <= reg_wdata_i[PHY_LSB +: ADDR_W];
      regad_q <= reg_wdata_i[REG_LSB +: ADDR_W];
    end else if (done) begin
      busy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      data_q <= '0;
    else if (done && !wr_q)
      data_q <= cap;
    else if (reg_we_i && reg_sel_i)
      data_q <= reg_wdata_i[DATA_W-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o[DATA_W-1:0] = data_q;
    end else begin
      reg_rdata_o[BUSY_BIT]              = busy_q;
      reg_rdata_o[WR_BIT]                = wr_q;
      reg_rdata_o[REG_LSB +: ADDR_W]     = regad_q;
      reg_rdata_o[PHY_LSB +: ADDR_W]     = phy_q;
    end
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_seq seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch),
    .wr_i    (reg_wdata_i[WR_BIT]),
    .phy_i   (reg_wdata_i[PHY_LSB +: ADDR_W]),
    .regad_i (reg_wdata_i[REG_LSB +: ADDR_W]),
    .wdata_i (data_q),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .cap_o   (cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              mdc_i,
  input logic              mdio_out_i,
  input logic              oe_i,
  input logic [2*ADDR_W:0] cmd_i,
  input logic              we_i,
  input logic              sel_i,
  input logic              wd0_i
);
  // R8
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);
  // R6
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);
  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(cmd_i));
  // R7
  mdio_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i && $past(mdc_i) |-> $stable(mdio_out_i));
  // R1
  launch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(we_i && !sel_i && wd0_i));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_q),
  .mdc_i      (mdc_o),
  .mdio_out_i (mdio_o),
  .oe_i       (mdio_oe_o),
  .cmd_i      (cmd_fields),
  .we_i       (reg_we_i),
  .sel_i      (reg_sel_i),
  .wd0_i      (reg_wdata_i[0])
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, oe, mdio_in;
  logic        resp_drv = 1'b0;
  logic        resp_bit = 1'b1;
  logic [15:0] rd_val = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int bit_cnt = 0;
  int rises = 0;
  int last_rise = 0;
  bit period_done = 1'b0;
  bit oe_err = 1'b0;
  logic [63:0] shift_v = '0;
  logic [63:0] exp_q[$];
  bit          exp_rd_q[$];

  always #10 clk = !clk;

  assign mdio_in = oe ? mdio_out : (resp_drv ? resp_bit : 1'b1);

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(oe), .mdio_i(mdio_in));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // monitor: collect each frame and compare with the scoreboard
  always @(posedge mdc) begin
    rises++;
    if (bit_cnt > 0 && !period_done) begin
      period_done = 1'b1;
      chk(cyc - last_rise == 20, "R8 mdc period", 64'(cyc - last_rise), 64'd20);
    end
    last_rise = cyc;
    if (exp_rd_q.size() > 0 && exp_rd_q[0] && bit_cnt >= 46 && oe) oe_err = 1'b1;
    shift_v = {shift_v[62:0], mdio_in};
    bit_cnt++;
    if (bit_cnt == 64) begin
      bit_cnt = 0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected frame", shift_v, 64'd0);
      end else begin
        logic [63:0] e;
        bit r;
        e = exp_q.pop_front();
        r = exp_rd_q.pop_front();
        chk(shift_v == e, "R7 R2 R4 R3 R5 frame bits", shift_v, e);
        if (r) chk(!oe_err, "R6 oe released in turnaround/data", 64'(oe_err), 64'd0);
        oe_err = 1'b0;
      end
    end
  end

  // PHY responder
  always @(negedge mdc) begin
    if (exp_rd_q.size() > 0 && exp_rd_q[0] && bit_cnt >= 47) begin
      resp_drv = 1'b1;
      resp_bit = (bit_cnt == 47) ? 1'b0 : rd_val[63 - bit_cnt];
    end else begin
      resp_drv = 1'b0;
    end
  end

  task automatic wr_reg(input bit s, input logic [31:0] v);
    @(negedge clk); we = 1'b1; sel = s; wdata = v;
    @(negedge clk); we = 1'b0; sel = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input bit s, output logic [31:0] v);
    @(negedge clk); sel = s; #1 v = rdata;
  endtask

  function automatic logic [31:0] cmd_word(bit go, bit w, logic [4:0] phy, logic [4:0] ra);
    logic [31:0] c;
    c = '0;
    c[0] = go; c[1] = w; c[8:4] = ra; c[16:12] = phy;
    return c;
  endfunction

  task automatic wait_idle(input string req);
    logic [31:0] v;
    bit idle;
    idle = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(1'b0, v);
      if (!v[0]) begin idle = 1'b1; break; end
    end
    chk(idle, req, 64'(v), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic launch(input bit w, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] d, input logic [15:0] rv);
    if (w) begin
      wr_reg(1'b1, {16'h0, d});
      exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d});
    end else begin
      exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 2'b10, rv});
    end
    exp_rd_q.push_back(!w);
    rd_val = rv;
    wr_reg(1'b0, cmd_word(1'b1, w, phy, ra));
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd_reg(1'b0, v);
    chk(v == 0, "R10 cmd after reset", 64'(v), 64'd0);
    chk(!mdc && !oe, "R10 mdc/oe after reset", 64'({mdc, oe}), 64'd0);

    // R11 store without launch
    r0 = rises;
    wr_reg(1'b0, cmd_word(1'b0, 1'b1, 5'h03, 5'h07));
    repeat (100) @(negedge clk);
    chk(rises == r0, "R11 no frame without busy", 64'(rises - r0), 64'd0);
    rd_reg(1'b0, v);
    chk(v == cmd_word(1'b0, 1'b1, 5'h03, 5'h07), "R11 fields readback", 64'(v),
        64'(cmd_word(1'b0, 1'b1, 5'h03, 5'h07)));

    // write frame, busy visible mid-frame
    launch(1'b1, 5'h01, 5'h00, 16'hA5C3, 16'h0);
    repeat (200) @(negedge clk);
    rd_reg(1'b0, v);
    chk(v[0] == 1'b1, "R1 busy during frame", 64'(v[0]), 64'd1);
    wait_idle("R1 busy clears");
    chk(exp_q.size() == 0, "R1 one frame per launch", 64'(exp_q.size()), 64'd0);
    chk(!mdc, "R8 mdc low when idle", 64'(mdc), 64'd0);

    // read frame
    launch(1'b0, 5'h1F, 5'h1F, 16'h0, 16'h8001);
    wait_idle("R1 busy clears read");
    rd_reg(1'b1, v);
    chk(v == 32'h8001, "R6 read data", 64'(v), 64'h8001);

    // write with ignored command while busy
    launch(1'b1, 5'h10, 5'h15, 16'h1234, 16'h0);
    repeat (300) @(negedge clk);
    wr_reg(1'b0, cmd_word(1'b1, 1'b0, 5'h0A, 5'h0B));
    rd_reg(1'b0, v);
    chk(v == cmd_word(1'b1, 1'b1, 5'h10, 5'h15), "R9 fields unchanged while busy", 64'(v),
        64'(cmd_word(1'b1, 1'b1, 5'h10, 5'h15)));
    wait_idle("R9 busy clears");
    chk(exp_q.size() == 0, "R9 no extra frame", 64'(exp_q.size()), 64'd0);

    // more read patterns
    launch(1'b0, 5'h00, 5'h00, 16'h0, 16'h0000);
    wait_idle("R6 busy clears zero read");
    rd_reg(1'b1, v);
    chk(v == 32'h0, "R6 read zeros", 64'(v), 64'h0);
    launch(1'b0, 5'h15, 5'h0A, 16'h0, 16'h5A3C);
    wait_idle("R6 busy clears read 2");
    rd_reg(1'b1, v);
    chk(v == 32'h5A3C, "R6 read pattern", 64'(v), 64'h5A3C);

    // write with data all ones, distinct addresses
    launch(1'b1, 5'h0E, 5'h11, 16'hFFFF, 16'h0);
    wait_idle("R5 busy clears");
    chk(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 64'd0);

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule